// File: doc/BRIEF.md
# Dual-Port Register File with Write Collision Flag

The block is a small register file of 32 words of 9 bits with two ports that run in the same clock cycle without waiting on each other. Each port can write a word, read a word, or do both in one cycle. Bit 8 of every word is an odd parity bit over bits 7:0. A port can compute this bit on a write or store it exactly as supplied. Every read is checked against the same rule, and a failure raises a flag for that port.

The storage is held as two copies, one feeding each port's read path. A write through either port goes into both copies, so the two ports always see the same contents. Each port holds its read word and parity flag in its own output register. That register loads only on a read, so the read data arrives one cycle after the address. When both ports write the same word in one cycle, port A's data is stored and a registered error flag pulses for one cycle. An active-low asynchronous reset clears the output registers and the error flags. It does not clear the array.

Top module: `dpreg_file`

## Requirements
- R1: While rst_ni is low, and after it rises until the next load, a_rdata_o, b_rdata_o, a_perr_o, b_perr_o and coll_o are all 0.
- R2: When x_re_i is high at a clock edge, x_rdata_o shows the stored word at x_addr_i from that edge onward.
- R3: A word written through either port at one edge can be read by both ports at the next edge.
- R4: A read at the same edge as a write to the same address, by either port, returns the word stored before that write.
- R5: With x_pgen_i high, the stored bit 8 equals the XNOR reduction of x_wdata_i[7:0], so the 9-bit word has an odd count of ones. With x_pgen_i low, x_wdata_i is stored unchanged.
- R6: x_perr_o is loaded together with x_rdata_o. It is 1 exactly when the loaded 9-bit word has an even count of ones.
- R7: coll_o is 1 for the single cycle after an edge at which both write enables were high and a_addr_i equalled b_addr_i. Otherwise it is 0.
- R8: When both ports write the same address at one edge, the stored word is port A's word.
- R9: When x_re_i is low at an edge, x_rdata_o and x_perr_o keep their values, whatever writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_we_i | input | 1 | Port A write enable |
| a_re_i | input | 1 | Port A read enable |
| a_pgen_i | input | 1 | Port A: compute the parity bit on write |
| a_addr_i | input | 5 | Port A word address |
| a_wdata_i | input | 9 | Port A write word |
| a_rdata_o | output | 9 | Port A registered read word |
| a_perr_o | output | 1 | Port A parity failure of the read word |
| b_we_i | input | 1 | Port B write enable |
| b_re_i | input | 1 | Port B read enable |
| b_pgen_i | input | 1 | Port B: compute the parity bit on write |
| b_addr_i | input | 5 | Port B word address |
| b_wdata_i | input | 9 | Port B write word |
| b_rdata_o | output | 9 | Port B registered read word |
| b_perr_o | output | 1 | Port B parity failure of the read word |
| coll_o | output | 1 | Same-address dual write seen at the previous edge |

## Verification
The bench forces both ports to write one address in the same cycle. A design with the wrong priority stores port B's word, and one with a wrong compare raises the flag on distinct addresses or holds it high too long. It reads a word through one port while the other port rewrites it, which catches a design that bypasses new data into the read. It writes through one port and reads through the other, which catches a copy that misses the cross-port write. It also stores words with deliberately bad parity and words with a computed parity bit, which exposes an inverted parity sense. It idles the read enables while writes continue, which exposes an output register that reloads when it should hold.

// File: rtl/dprf_pkg.sv
package dprf_pkg;
  // value that makes the count of ones odd once appended
  function automatic logic odd_fill(input logic [63:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/dprf_bank.sv
module dprf_bank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 9,
  parameter int unsigned AW    = 5
) (
  input  logic             clk_i,
  input  logic             a_we_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [WIDTH-1:0] a_word_i,
  input  logic             b_we_i,
  input  logic [AW-1:0]    b_addr_i,
  input  logic [WIDTH-1:0] b_word_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_word_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // port A assigned last: wins on same-address writes
  always_ff @(posedge clk_i) begin
    if (b_we_i) mem_q[b_addr_i] <= b_word_i;
    if (a_we_i) mem_q[a_addr_i] <= a_word_i;
  end

  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/dprf_rport.sv
module dprf_rport #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             perr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      perr_o  <= 1'b0;
    end else if (re_i) begin
      rdata_o <= word_i;
      perr_o  <= ~(^word_i);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(re_i)) |-> ($stable(rdata_o) && $stable(perr_o))); // R9
  AST_PERR_TRACKS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(re_i)) |-> (perr_o == ~(^rdata_o))); // R6
endmodule

// File: rtl/dpreg_file.sv
module dpreg_file #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_we_i,
  input  logic             a_re_i,
  input  logic             a_pgen_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [WIDTH-1:0] a_wdata_i,
  output logic [WIDTH-1:0] a_rdata_o,
  output logic             a_perr_o,
  input  logic             b_we_i,
  input  logic             b_re_i,
  input  logic             b_pgen_i,
  input  logic [AW-1:0]    b_addr_i,
  input  logic [WIDTH-1:0] b_wdata_i,
  output logic [WIDTH-1:0] b_rdata_o,
  output logic             b_perr_o,
  output logic             coll_o
);
  import dprf_pkg::*;

  localparam int unsigned NPORT = 2;
  localparam int unsigned PW    = WIDTH - 1;

  logic [NPORT-1:0]            re, pgen, perr;
  logic [NPORT-1:0][AW-1:0]    addr;
  logic [NPORT-1:0][WIDTH-1:0] wdata, wword, rword, rdata;

  assign re    = {b_re_i, a_re_i};
  assign pgen  = {b_pgen_i, a_pgen_i};
  assign addr  = {b_addr_i, a_addr_i};
  assign wdata = {b_wdata_i, a_wdata_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign wword[p] = pgen[p] ? {odd_fill(64'(wdata[p][PW-1:0])), wdata[p][PW-1:0]}
                              : wdata[p];

    // copy p serves the reads of port p; both copies take both writes
    dprf_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_bank (
      .clk_i    (clk_i),
      .a_we_i   (a_we_i),
      .a_addr_i (a_addr_i),
      .a_word_i (wword[0]),
      .b_we_i   (b_we_i),
      .b_addr_i (b_addr_i),
      .b_word_i (wword[1]),
      .rd_addr_i(addr[p]),
      .rd_word_o(rword[p])
    );

    dprf_rport #(.WIDTH(WIDTH)) u_rport (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .re_i   (re[p]),
      .word_i (rword[p]),
      .rdata_o(rdata[p]),
      .perr_o (perr[p])
    );
  end

  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];
  assign a_perr_o  = perr[0];
  assign b_perr_o  = perr[1];

  logic same_wr;
  assign same_wr = a_we_i && b_we_i && (a_addr_i == b_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coll_o <= 1'b0;
    else         coll_o <= same_wr;
  end

  AST_COLL_NEEDS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |-> $past(a_we_i)); // R7
  AST_COLL_NEEDS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |-> $past(b_we_i)); // R7
  AST_NO_COLL_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(a_addr_i) != $past(b_addr_i)) |-> !coll_o); // R7
endmodule

// File: tb/dpreg_file_tb.sv
`timescale 1ns/1ps
module dpreg_file_tb;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned WIDTH = 9;
  localparam int unsigned AW    = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic a_we_i, a_re_i, a_pgen_i, b_we_i, b_re_i, b_pgen_i;
  logic [AW-1:0] a_addr_i, b_addr_i;
  logic [WIDTH-1:0] a_wdata_i, b_wdata_i, a_rdata_o, b_rdata_o;
  logic a_perr_o, b_perr_o, coll_o;

  always #2 clk_i = ~clk_i;

  dpreg_file #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (.*);

  int total = 0;
  int bad = 0;
  logic [WIDTH-1:0] mdl [DEPTH];
  logic [WIDTH-1:0] exp_ard = '0, exp_brd = '0;
  logic exp_ape = 1'b0, exp_bpe = 1'b0, exp_coll = 1'b0;

  function automatic logic [WIDTH-1:0] enc(input logic [WIDTH-1:0] d, input logic g);
    return g ? {~(^d[7:0]), d[7:0]} : d;
  endfunction

  task automatic chk(input string tag, input string what, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    a_we_i = 0; a_re_i = 0; a_pgen_i = 0; a_addr_i = '0; a_wdata_i = '0;
    b_we_i = 0; b_re_i = 0; b_pgen_i = 0; b_addr_i = '0; b_wdata_i = '0;
  endtask

  // inputs already set at a negedge; run one edge and check all outputs
  task automatic step(input string tag);
    if (a_re_i) begin exp_ard = mdl[a_addr_i]; exp_ape = ~(^mdl[a_addr_i]); end
    if (b_re_i) begin exp_brd = mdl[b_addr_i]; exp_bpe = ~(^mdl[b_addr_i]); end
    exp_coll = a_we_i && b_we_i && (a_addr_i == b_addr_i);
    if (b_we_i) mdl[b_addr_i] = enc(b_wdata_i, b_pgen_i);
    if (a_we_i) mdl[a_addr_i] = enc(a_wdata_i, a_pgen_i);
    @(posedge clk_i); #1;
    chk(tag, "a_rdata", a_rdata_o, exp_ard);
    chk(tag, "b_rdata", b_rdata_o, exp_brd);
    chk(tag, "a_perr", 9'(a_perr_o), 9'(exp_ape));
    chk(tag, "b_perr", 9'(b_perr_o), 9'(exp_bpe));
    chk(tag, "coll", 9'(coll_o), 9'(exp_coll));
    @(negedge clk_i);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1977);
    idle();
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", "a_rdata", a_rdata_o, '0);
    chk("R1", "b_rdata", b_rdata_o, '0);
    chk("R1", "flags", {6'd0, a_perr_o, b_perr_o, coll_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1");

    // fill every word, port A low half, port B high half
    for (int i = 0; i < DEPTH / 2; i++) begin
      idle();
      a_we_i = 1; a_pgen_i = 1; a_addr_i = AW'(i); a_wdata_i = WIDTH'($urandom);
      b_we_i = 1; b_pgen_i = 1; b_addr_i = AW'(i + DEPTH / 2); b_wdata_i = WIDTH'($urandom);
      step("R3");
    end
    // cross reads: each port reads what the other wrote
    for (int i = 0; i < DEPTH; i++) begin
      idle();
      a_re_i = 1; a_addr_i = AW'(i);
      b_re_i = 1; b_addr_i = AW'(DEPTH - 1 - i);
      step("R3");
    end

    // R5 computed parity overrides given bit 8
    idle(); a_we_i = 1; a_pgen_i = 1; a_addr_i = 5'd3; a_wdata_i = 9'h0FF; step("R5");
    idle(); b_re_i = 1; b_addr_i = 5'd3; step("R5");
    // R6 stored-as-given even word flags error
    idle(); b_we_i = 1; b_pgen_i = 0; b_addr_i = 5'd4; b_wdata_i = 9'h0FF; step("R6");
    idle(); a_re_i = 1; a_addr_i = 5'd4; b_re_i = 1; b_addr_i = 5'd3; step("R6");

    // R4 read during other port's write returns old word
    idle(); a_we_i = 1; a_pgen_i = 1; a_addr_i = 5'd5; a_wdata_i = 9'h05A;
    b_re_i = 1; b_addr_i = 5'd5; step("R4");
    idle(); b_we_i = 1; b_pgen_i = 0; b_addr_i = 5'd5; b_wdata_i = 9'h1C3;
    a_re_i = 1; a_addr_i = 5'd5; step("R4");
    idle(); a_re_i = 1; a_addr_i = 5'd5; b_re_i = 1; b_addr_i = 5'd5; step("R4");

    // R7 / R8 same-address dual write
    idle(); a_we_i = 1; a_addr_i = 5'd7; a_wdata_i = 9'h111;
    b_we_i = 1; b_addr_i = 5'd7; b_wdata_i = 9'h0EE; step("R7");
    idle(); a_re_i = 1; a_addr_i = 5'd7; b_re_i = 1; b_addr_i = 5'd7; step("R8");
    idle(); a_we_i = 1; a_addr_i = 5'd8; b_we_i = 1; b_addr_i = 5'd9; step("R7");
    idle(); a_we_i = 1; a_addr_i = 5'd9; b_we_i = 1; b_addr_i = 5'd9; step("R7");
    idle(); step("R7");

    // R9 outputs hold while writes continue
    for (int i = 0; i < 6; i++) begin
      idle();
      a_we_i = 1; a_addr_i = 5'd5; a_wdata_i = WIDTH'($urandom);
      b_we_i = 1; b_addr_i = 5'd7; b_wdata_i = WIDTH'($urandom);
      a_addr_i = (i % 2 == 0) ? 5'd5 : 5'd7;
      step("R9");
    end

    // random traffic with forced collisions
    for (int i = 0; i < 4000; i++) begin
      a_we_i = 1'($urandom); a_re_i = 1'($urandom); a_pgen_i = 1'($urandom);
      b_we_i = 1'($urandom); b_re_i = 1'($urandom); b_pgen_i = 1'($urandom);
      a_addr_i = AW'($urandom); b_addr_i = AW'($urandom);
      a_wdata_i = WIDTH'($urandom); b_wdata_i = WIDTH'($urandom);
      if ($urandom % 8 == 0) begin a_we_i = 1; b_we_i = 1; b_addr_i = a_addr_i; end
      step("R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule